// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits ahead of a private cache's line controller. Three message queues present their head entries to it. The first carries responses from the outer cache level, the second carries requests that the outer level forwards, and the third carries requests and invalidation acknowledgements from the inner (closer-to-core) cache. In each cycle the classifier picks one head by fixed priority. It then turns the message type, the looked-up line state and the outstanding-acknowledgement arithmetic into a single event code for the controller.

For an inner-cache request that misses when no way is free, the block raises the event against the victim line instead of the requested line. That event is an inner-cache invalidation when the inner cache still holds the victim, and a plain replacement otherwise. The request itself stays at the head of its queue. The block also derives the outer bank index from the target address. Lookups, the victim choice and the queue storage all live outside the block and arrive as inputs. The output is a valid/ready handshake. When ready is low, no queue is popped and the choice is made again in the next cycle.

Top module: `coh_event_classifier`

## Requirements
- R1: Fixed priority applies in every cycle: the outer response queue wins over the forwarded queue, and the forwarded queue wins over the inner queue. `out_src` reports the winner as 0 (response), 1 (forwarded) or 2 (inner).
- R2: `out_valid` is high exactly when any queue is valid. At most one pop strobe is high, and only the strobe of the selected queue, and only while `out_ready` is high. When `out_ready` is low nothing is popped.
- R3: Response type codes are 0 data, 1 exclusive data, 2 ack and 3 writeback ack. Exclusive data gives event 13, writeback ack gives event 18, and codes 4 to 7 give the error event 0.
- R4: A data response for a line in state 8 (IS) or 11 (IS_I) that comes from a peer cache (`rsp_from_peer`=1) gives event 14.
- R5: Any other data response gives event 15 when `rsp_pending` equals `rsp_acks`, and event 12 when they differ.
- R6: An ack response gives event 17 when `rsp_pending` equals `rsp_acks`, and event 16 otherwise.
- R7: Forwarded type codes are 0 invalidate, 1 exclusive get, 2 upgrade and 3 shared get. Any of these gives event 8 when `fwd_hit` is set and the line state is one of 2, 4, 6, 14, 15, 16 or 18, the states in which the inner cache holds a copy.
- R8: In every other case a forwarded invalidate gives event 6, exclusive get and upgrade give event 10, and shared get gives event 11.
- R9: Inner type codes are 0 shared get, 1 exclusive get, 2 upgrade, 3 writeback, 4 data-carrying ack and 5 ack, and 6 to 7 are errors. Acks map to 4 and 5. A request that hits or finds a free way maps to 1 (shared get), 2 (exclusive get or upgrade) or 3 (writeback). Error codes give event 0.
- R10: An inner request that misses with no free way gives event 7 when `vic_valid` is set and `vic_state` is in the R7 set, and event 9 otherwise. In both cases `out_addr` equals `vic_addr` and `inr_pop` stays low.
- R11: `out_bank` equals the `BANK_BITS` address bits of `out_addr` that lie just above the `BLK_OFF` block-offset bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rsp_valid | input | 1 | Outer response queue has a head entry |
| rsp_type | input | 3 | Response type code |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_state | input | 5 | Line state for the response address |
| rsp_from_peer | input | 1 | Response was sent by a peer cache |
| rsp_pending | input | ACK_W | Outstanding acknowledgements for the line |
| rsp_acks | input | ACK_W | Ack count carried by the response |
| rsp_pop | output | 1 | Dequeue the response head |
| fwd_valid | input | 1 | Forwarded request queue has a head entry |
| fwd_type | input | 2 | Forwarded request type code |
| fwd_addr | input | ADDR_W | Forwarded request line address |
| fwd_hit | input | 1 | Line is present in this cache |
| fwd_state | input | 5 | Line state for the forwarded address |
| fwd_pop | output | 1 | Dequeue the forwarded head |
| inr_valid | input | 1 | Inner queue has a head entry |
| inr_type | input | 3 | Inner message type code |
| inr_addr | input | ADDR_W | Inner message line address |
| inr_hit | input | 1 | Requested line is present in this cache |
| inr_way_free | input | 1 | A way is free in the target set |
| vic_addr | input | ADDR_W | Address of the chosen victim |
| vic_valid | input | 1 | Victim entry is valid |
| vic_state | input | 5 | Victim line state |
| inr_pop | output | 1 | Dequeue the inner head |
| out_valid | output | 1 | An event is offered |
| out_ready | input | 1 | Controller accepts the event |
| out_event | output | 5 | Event code |
| out_addr | output | ADDR_W | Address the event applies to |
| out_src | output | 2 | Source queue of the event |
| out_bank | output | BANK_BITS | Outer bank index of out_addr |

## Verification
Two functions can act in the same cycle: the inner queue's eviction decision and the arbitration against a higher-priority queue. The bench provokes this by presenting an outer response together with an inner miss that has no free way, and it also withholds `out_ready` while an eviction is offered. The response must win, and `inr_pop` must stay low in both cases. This shows that the victim path never pops the inner queue, whether the inner queue lost arbitration or was stalled.

// File: rtl/coh_cls_pkg.sv
package coh_cls_pkg;

    typedef enum logic [4:0] {
        EV_ERROR        = 5'd0,
        EV_LOAD         = 5'd1,
        EV_STORE        = 5'd2,
        EV_WRITEBACK    = 5'd3,
        EV_L0_DATA_ACK  = 5'd4,
        EV_L0_ACK       = 5'd5,
        EV_OUTER_INV    = 5'd6,
        EV_L0_INV_OWN   = 5'd7,
        EV_L0_INV_OTHER = 5'd8,
        EV_EVICT        = 5'd9,
        EV_FWD_EXCL     = 5'd10,
        EV_FWD_SHARED   = 5'd11,
        EV_DATA_PARTIAL = 5'd12,
        EV_DATA_EXCL    = 5'd13,
        EV_DATA_PEER    = 5'd14,
        EV_DATA_DONE    = 5'd15,
        EV_ACK_PARTIAL  = 5'd16,
        EV_ACK_DONE     = 5'd17,
        EV_WB_DONE      = 5'd18
    } evt_e;

    typedef enum logic [4:0] {
        LS_NP = 5'd0, LS_I = 5'd1, LS_S = 5'd2, LS_SS = 5'd3,
        LS_E = 5'd4, LS_EE = 5'd5, LS_M = 5'd6, LS_MM = 5'd7,
        LS_IS = 5'd8, LS_IM = 5'd9, LS_SM = 5'd10, LS_IS_I = 5'd11,
        LS_M_I = 5'd12, LS_SINK = 5'd13, LS_S_IL0 = 5'd14,
        LS_E_IL0 = 5'd15, LS_M_IL0 = 5'd16, LS_MM_IL0 = 5'd17,
        LS_SM_IL0 = 5'd18
    } line_e;

    localparam logic [2:0] RSP_DATA = 3'd0;
    localparam logic [2:0] RSP_DATA_EXCL = 3'd1;
    localparam logic [2:0] RSP_ACK = 3'd2;
    localparam logic [2:0] RSP_WB_ACK = 3'd3;

    localparam logic [1:0] FWD_INV = 2'd0;
    localparam logic [1:0] FWD_GETX = 2'd1;
    localparam logic [1:0] FWD_UPGRADE = 2'd2;
    localparam logic [1:0] FWD_GETS = 2'd3;

    localparam logic [2:0] INR_GETS = 3'd0;
    localparam logic [2:0] INR_GETX = 3'd1;
    localparam logic [2:0] INR_UPGRADE = 3'd2;
    localparam logic [2:0] INR_PUTX = 3'd3;
    localparam logic [2:0] INR_INV_DATA = 3'd4;
    localparam logic [2:0] INR_INV_ACK = 3'd5;

    localparam int NUM_Q = 3;
    localparam int SRC_W = 2;

    function automatic logic held_inner(input logic [4:0] st);
        return (st == LS_S) || (st == LS_E) || (st == LS_M) ||
               (st == LS_S_IL0) || (st == LS_E_IL0) ||
               (st == LS_M_IL0) || (st == LS_SM_IL0);
    endfunction

endpackage

// File: rtl/coh_cls_arbiter.sv
module coh_cls_arbiter #(
    parameter int N = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] taken;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_pri
        assign grant[i]   = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/coh_cls_outer.sv
module coh_cls_outer
    import coh_cls_pkg::*;
#(
    parameter int ACK_W = 4
) (
    input  logic [2:0]       rsp_type,
    input  logic [4:0]       rsp_state,
    input  logic             rsp_from_peer,
    input  logic [ACK_W-1:0] rsp_pending,
    input  logic [ACK_W-1:0] rsp_acks,
    input  logic [1:0]       fwd_type,
    input  logic             fwd_hit,
    input  logic [4:0]       fwd_state,
    output evt_e             rsp_evt,
    output evt_e             fwd_evt
);
    logic acks_settled;
    logic rsp_waiting_shared;

    assign acks_settled       = (rsp_pending == rsp_acks);
    assign rsp_waiting_shared = (rsp_state == LS_IS) || (rsp_state == LS_IS_I);

    always_comb begin
        unique case (rsp_type)
            RSP_DATA_EXCL: rsp_evt = EV_DATA_EXCL;
            RSP_WB_ACK:    rsp_evt = EV_WB_DONE;
            RSP_DATA: begin
                if (rsp_waiting_shared && rsp_from_peer) rsp_evt = EV_DATA_PEER;
                else if (acks_settled)                   rsp_evt = EV_DATA_DONE;
                else                                     rsp_evt = EV_DATA_PARTIAL;
            end
            RSP_ACK:       rsp_evt = acks_settled ? EV_ACK_DONE : EV_ACK_PARTIAL;
            default:       rsp_evt = EV_ERROR;
        endcase
    end

    always_comb begin
        if (fwd_hit && held_inner(fwd_state)) begin
            fwd_evt = EV_L0_INV_OTHER;
        end else begin
            unique case (fwd_type)
                FWD_INV:     fwd_evt = EV_OUTER_INV;
                FWD_GETX:    fwd_evt = EV_FWD_EXCL;
                FWD_UPGRADE: fwd_evt = EV_FWD_EXCL;
                default:     fwd_evt = EV_FWD_SHARED;
            endcase
        end
    end
endmodule

// File: rtl/coh_cls_inner.sv
module coh_cls_inner
    import coh_cls_pkg::*;
(
    input  logic [2:0] inr_type,
    input  logic       inr_hit,
    input  logic       inr_way_free,
    input  logic       vic_valid,
    input  logic [4:0] vic_state,
    output evt_e       inr_evt,
    output logic       use_victim
);
    evt_e req_evt;
    logic is_request;
    evt_e victim_evt;

    always_comb begin
        is_request = 1'b1;
        unique case (inr_type)
            INR_GETS:    req_evt = EV_LOAD;
            INR_GETX:    req_evt = EV_STORE;
            INR_UPGRADE: req_evt = EV_STORE;
            INR_PUTX:    req_evt = EV_WRITEBACK;
            INR_INV_DATA: begin req_evt = EV_L0_DATA_ACK; is_request = 1'b0; end
            INR_INV_ACK:  begin req_evt = EV_L0_ACK;      is_request = 1'b0; end
            default:      begin req_evt = EV_ERROR;       is_request = 1'b0; end
        endcase
    end

    assign victim_evt = (vic_valid && held_inner(vic_state)) ? EV_L0_INV_OWN : EV_EVICT;
    assign use_victim = is_request && !inr_hit && !inr_way_free;
    assign inr_evt    = use_victim ? victim_evt : req_evt;
endmodule

// File: rtl/coh_event_classifier.sv
module coh_event_classifier
    import coh_cls_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_OFF   = 6,
    parameter int BANK_BITS = 2,
    parameter int ACK_W     = 4
) (
    input  logic                 rsp_valid,
    input  logic [2:0]           rsp_type,
    input  logic [ADDR_W-1:0]    rsp_addr,
    input  logic [4:0]           rsp_state,
    input  logic                 rsp_from_peer,
    input  logic [ACK_W-1:0]     rsp_pending,
    input  logic [ACK_W-1:0]     rsp_acks,
    output logic                 rsp_pop,
    input  logic                 fwd_valid,
    input  logic [1:0]           fwd_type,
    input  logic [ADDR_W-1:0]    fwd_addr,
    input  logic                 fwd_hit,
    input  logic [4:0]           fwd_state,
    output logic                 fwd_pop,
    input  logic                 inr_valid,
    input  logic [2:0]           inr_type,
    input  logic [ADDR_W-1:0]    inr_addr,
    input  logic                 inr_hit,
    input  logic                 inr_way_free,
    input  logic [ADDR_W-1:0]    vic_addr,
    input  logic                 vic_valid,
    input  logic [4:0]           vic_state,
    output logic                 inr_pop,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [4:0]           out_event,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [SRC_W-1:0]     out_src,
    output logic [BANK_BITS-1:0] out_bank
);
    localparam int Q_RSP = 0;
    localparam int Q_FWD = 1;
    localparam int Q_INR = 2;

    logic [NUM_Q-1:0] req;
    logic [NUM_Q-1:0] grant;
    logic [SRC_W-1:0] sel;
    evt_e             rsp_evt, fwd_evt, inr_evt;
    logic             use_victim;

    assign req = {inr_valid, fwd_valid, rsp_valid};

    coh_cls_arbiter #(.N(NUM_Q)) u_arb (
        .req   (req),
        .grant (grant),
        .idx   (sel)
    );

    coh_cls_outer #(.ACK_W(ACK_W)) u_outer (
        .rsp_type      (rsp_type),
        .rsp_state     (rsp_state),
        .rsp_from_peer (rsp_from_peer),
        .rsp_pending   (rsp_pending),
        .rsp_acks      (rsp_acks),
        .fwd_type      (fwd_type),
        .fwd_hit       (fwd_hit),
        .fwd_state     (fwd_state),
        .rsp_evt       (rsp_evt),
        .fwd_evt       (fwd_evt)
    );

    coh_cls_inner u_inner (
        .inr_type     (inr_type),
        .inr_hit      (inr_hit),
        .inr_way_free (inr_way_free),
        .vic_valid    (vic_valid),
        .vic_state    (vic_state),
        .inr_evt      (inr_evt),
        .use_victim   (use_victim)
    );

    assign out_valid = |req;
    assign out_src   = sel;

    always_comb begin
        unique case (sel)
            SRC_W'(Q_RSP): begin out_event = rsp_evt; out_addr = rsp_addr; end
            SRC_W'(Q_FWD): begin out_event = fwd_evt; out_addr = fwd_addr; end
            SRC_W'(Q_INR): begin
                out_event = inr_evt;
                out_addr  = use_victim ? vic_addr : inr_addr;
            end
            default:       begin out_event = EV_ERROR; out_addr = '0; end
        endcase
    end

    assign rsp_pop = grant[Q_RSP] & out_ready;
    assign fwd_pop = grant[Q_FWD] & out_ready;
    assign inr_pop = grant[Q_INR] & out_ready & ~use_victim;

    assign out_bank = out_addr[BLK_OFF +: BANK_BITS];
endmodule

// File: rtl/coh_event_classifier_chk.sv
module coh_event_classifier_chk #(
    parameter int ADDR_W = 32
) (
    input logic              rsp_valid,
    input logic              fwd_valid,
    input logic              inr_valid,
    input logic              rsp_pop,
    input logic              fwd_pop,
    input logic              inr_pop,
    input logic              out_valid,
    input logic              out_ready,
    input logic [4:0]        out_event,
    input logic [1:0]        out_src,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] vic_addr
);
    logic evict_evt;
    assign evict_evt = out_valid && (out_src == 2'd2) &&
                       ((out_event == 5'd7) || (out_event == 5'd9));

    always_comb begin
        assert_single_pop_R2: assert ($onehot0({rsp_pop, fwd_pop, inr_pop}));
        assert_pop_ready_R2: assert (!(rsp_pop || fwd_pop || inr_pop) || out_ready);
        assert_valid_any_R2: assert (out_valid == (rsp_valid || fwd_valid || inr_valid));
        assert_fwd_yields_R1: assert (!fwd_pop || !rsp_valid);
        assert_inner_yields_R1: assert (!inr_pop || (!rsp_valid && !fwd_valid));
        assert_victim_keeps_R10: assert (!evict_evt || !inr_pop);
        assert_victim_addr_R10: assert (!evict_evt || (out_addr == vic_addr));
    end
endmodule

bind coh_event_classifier coh_event_classifier_chk #(.ADDR_W(ADDR_W)) u_chk (
    .rsp_valid (rsp_valid),
    .fwd_valid (fwd_valid),
    .inr_valid (inr_valid),
    .rsp_pop   (rsp_pop),
    .fwd_pop   (fwd_pop),
    .inr_pop   (inr_pop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_event (out_event),
    .out_src   (out_src),
    .out_addr  (out_addr),
    .vic_addr  (vic_addr)
);

// File: tb/coh_event_classifier_test.sv
module coh_event_classifier_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rsp_valid, rsp_from_peer, rsp_pop;
    logic [2:0]  rsp_type;
    logic [31:0] rsp_addr;
    logic [4:0]  rsp_state;
    logic [3:0]  rsp_pending, rsp_acks;
    logic        fwd_valid, fwd_hit, fwd_pop;
    logic [1:0]  fwd_type;
    logic [31:0] fwd_addr;
    logic [4:0]  fwd_state;
    logic        inr_valid, inr_hit, inr_way_free, vic_valid, inr_pop;
    logic [2:0]  inr_type;
    logic [31:0] inr_addr, vic_addr;
    logic [4:0]  vic_state;
    logic        out_valid, out_ready;
    logic [4:0]  out_event;
    logic [31:0] out_addr;
    logic [1:0]  out_src;
    logic [1:0]  out_bank;

    int checks = 0;
    int errors = 0;

    coh_event_classifier uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        rsp_valid = 0; rsp_type = 0; rsp_addr = 32'h100; rsp_state = 0;
        rsp_from_peer = 0; rsp_pending = 0; rsp_acks = 0;
        fwd_valid = 0; fwd_type = 0; fwd_addr = 32'h200; fwd_hit = 0; fwd_state = 0;
        inr_valid = 0; inr_type = 0; inr_addr = 32'h300; inr_hit = 1;
        inr_way_free = 1; vic_addr = 32'h440; vic_valid = 0; vic_state = 0;
        out_ready = 1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_idle();
        @(negedge clk); clear_all(); settle();
        chk("R2 idle valid", out_valid, 0);
        chk("R2 idle pops", {rsp_pop, fwd_pop, inr_pop}, 0);
    endtask

    task automatic t_priority();
        @(negedge clk); clear_all();
        rsp_valid = 1; fwd_valid = 1; inr_valid = 1; settle();
        chk("R1 rsp wins src", out_src, 0);
        chk("R1 rsp wins pops", {rsp_pop, fwd_pop, inr_pop}, 3'b100);
        chk("R1 rsp addr", out_addr, 32'h100);
        rsp_valid = 0; settle();
        chk("R1 fwd next src", out_src, 1);
        chk("R1 fwd pops", {rsp_pop, fwd_pop, inr_pop}, 3'b010);
        fwd_valid = 0; settle();
        chk("R1 inner last src", out_src, 2);
        chk("R1 inner pop", inr_pop, 1);
    endtask

    task automatic t_stall();
        @(negedge clk); clear_all();
        fwd_valid = 1; inr_valid = 1; out_ready = 0; settle();
        chk("R2 stall valid", out_valid, 1);
        chk("R2 stall no pop", {rsp_pop, fwd_pop, inr_pop}, 0);
        @(negedge clk); rsp_valid = 1; settle();
        chk("R2 rearbitrate src", out_src, 0);
        out_ready = 1; settle();
        chk("R2 release pop", {rsp_pop, fwd_pop, inr_pop}, 3'b100);
    endtask

    task automatic t_rsp_types();
        @(negedge clk); clear_all(); rsp_valid = 1;
        rsp_type = 1; settle(); chk("R3 excl data", out_event, 13);
        rsp_type = 3; settle(); chk("R3 wb ack", out_event, 18);
        rsp_type = 5; settle(); chk("R3 bad type", out_event, 0);
        rsp_type = 7; settle(); chk("R3 bad type 7", out_event, 0);
    endtask

    task automatic t_data();
        @(negedge clk); clear_all(); rsp_valid = 1; rsp_type = 0;
        rsp_state = 8; rsp_from_peer = 1; rsp_pending = 3; rsp_acks = 1; settle();
        chk("R4 peer IS", out_event, 14);
        rsp_state = 11; settle(); chk("R4 peer IS_I", out_event, 14);
        rsp_state = 9; rsp_pending = 2; rsp_acks = 2; settle();
        chk("R5 data done", out_event, 15);
        rsp_pending = 3; rsp_acks = 1; settle();
        chk("R5 data partial", out_event, 12);
        rsp_state = 8; rsp_from_peer = 0; rsp_pending = 0; rsp_acks = 0; settle();
        chk("R5 IS outer data", out_event, 15);
    endtask

    task automatic t_ack();
        @(negedge clk); clear_all(); rsp_valid = 1; rsp_type = 2;
        rsp_pending = 2; rsp_acks = 2; settle(); chk("R6 ack done", out_event, 17);
        rsp_acks = 1; settle(); chk("R6 ack partial", out_event, 16);
    endtask

    task automatic t_fwd();
        @(negedge clk); clear_all(); fwd_valid = 1;
        fwd_hit = 1; fwd_state = 2; fwd_type = 3; settle();
        chk("R7 S gets", out_event, 8);
        fwd_state = 18; fwd_type = 0; settle(); chk("R7 SM_IL0 inv", out_event, 8);
        fwd_state = 16; fwd_type = 1; settle(); chk("R7 M_IL0 getx", out_event, 8);
        fwd_state = 5; fwd_type = 1; settle(); chk("R8 getx", out_event, 10);
        fwd_type = 2; settle(); chk("R8 upgrade", out_event, 10);
        fwd_type = 3; settle(); chk("R8 gets", out_event, 11);
        fwd_type = 0; settle(); chk("R8 inv", out_event, 6);
        fwd_hit = 0; fwd_state = 2; settle(); chk("R8 miss inv", out_event, 6);
    endtask

    task automatic t_inner();
        @(negedge clk); clear_all(); inr_valid = 1;
        inr_type = 4; inr_hit = 0; inr_way_free = 0; settle();
        chk("R9 data ack", out_event, 4);
        chk("R9 data ack pop", inr_pop, 1);
        inr_type = 5; settle(); chk("R9 ack", out_event, 5);
        inr_type = 0; inr_hit = 1; settle(); chk("R9 load", out_event, 1);
        chk("R9 load addr", out_addr, 32'h300);
        inr_type = 1; inr_hit = 0; inr_way_free = 1; settle();
        chk("R9 store", out_event, 2);
        inr_type = 2; settle(); chk("R9 upgrade", out_event, 2);
        inr_type = 3; settle(); chk("R9 writeback", out_event, 3);
        inr_type = 7; settle(); chk("R9 bad type", out_event, 0);
    endtask

    task automatic t_victim();
        @(negedge clk); clear_all(); inr_valid = 1;
        inr_type = 0; inr_hit = 0; inr_way_free = 0;
        vic_valid = 1; vic_state = 6; settle();
        chk("R10 own inval", out_event, 7);
        chk("R10 victim addr", out_addr, 32'h440);
        chk("R10 kept", inr_pop, 0);
        vic_state = 7; settle(); chk("R10 replace", out_event, 9);
        vic_valid = 0; vic_state = 2; settle(); chk("R10 invalid victim", out_event, 9);
        chk("R10 kept again", inr_pop, 0);
    endtask

    task automatic t_bank();
        @(negedge clk); clear_all(); rsp_valid = 1;
        rsp_addr = 32'h0000_00C0; settle(); chk("R11 bank 3", out_bank, 3);
        rsp_addr = 32'h0000_107F; settle(); chk("R11 bank 1", out_bank, 1);
    endtask

    task automatic t_overlap();
        @(negedge clk); clear_all();
        inr_valid = 1; inr_hit = 0; inr_way_free = 0; vic_valid = 1; vic_state = 4;
        rsp_valid = 1; rsp_type = 3; settle();
        chk("R1 overlap src", out_src, 0);
        chk("R10 overlap inner kept", inr_pop, 0);
        rsp_valid = 0; out_ready = 0; settle();
        chk("R10 stalled evict event", out_event, 7);
        chk("R2 stalled evict no pop", inr_pop, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_all();
        t_idle();
        t_priority();
        t_stall();
        t_rsp_types();
        t_data();
        t_ack();
        t_fwd();
        t_inner();
        t_victim();
        t_bank();
        t_overlap();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule